// File: doc/BRIEF.md
# Flash Write-Protect and Write-Enable Gate

This block sits on the device side of a serial NOR flash, between the command decoder and the array sequencer. It decides whether a program, an erase or a status write may begin. The command decoder hands it one decoded command each time chip select rises. The command carries an opcode, the 4 KB sector index of the target address, the number of data bits clocked in, and up to two status bytes. The gate answers every command with exactly one pulse, either accept or ignore, in the following cycle. It owns the write-enable latch, the busy flag and the protection configuration, and it publishes two 8-bit status bytes for the read-status path.

The array is 2 MB: 32 blocks of 64 KB, or 512 sectors of 4 KB. A three-bit protect level selects a protected span at one end of the array. The span is counted in 64 KB blocks, or in 4 KB sectors when fine granularity is selected. A direction bit chooses the top or the bottom end, and a complement bit inverts the protected set. A modifying command whose target region touches any protected sector is refused as a whole. The real non-volatile write time is modelled by a per-class cycle counter.

Top module: `wrprot_gate`

## Requirements
- R1: After synchronous reset both status bytes read 00h, busy is low and the write-enable latch is clear.
- R2: Opcode 06h sets the write-enable latch and 04h clears it. The modifying opcodes (02h program, 20h, 52h, D8h, C7h, 60h erase, 01h status write) are ignored while the latch is clear.
- R3: With fine granularity off, protect level L in 1..5 protects 2^(L-1) blocks of 64 KB, and levels 6 and 7 protect the whole array. The span lies at the top of the array when the direction bit is 0 and at the bottom when it is 1.
- R4: With fine granularity on, levels 1, 2 and 3 protect 1, 2 and 4 sectors of 4 KB, levels 4 and 5 protect 8 sectors, and levels 6 and 7 protect the whole array.
- R5: With the complement bit set, the protected set is every sector outside the span of R3/R4. Level 0 then protects the whole array.
- R6: The target region is one sector for 02h and 20h, the aligned 32 KB block for 52h, the aligned 64 KB block for D8h, and the whole array for C7h and 60h. A region overlapping any protected sector is ignored as a whole.
- R7: While busy, only 05h and 35h (status reads) are accepted. Every other command is ignored, and neither the latch nor the status bits change.
- R8: An accepted command holds busy for PROG_CYC (program), ERASE_CYC (any erase) or SRW_CYC (status write) cycles. The latch is clear by the time busy falls, and a status write's new values appear when busy falls.
- R9: A modifying command that is refused while not busy clears the write-enable latch.
- R10: A status write needs exactly 8 or 16 data bits. With 8 bits only status byte 1 changes, with 16 bits both bytes change, and any other count is ignored.
- R11: A status write is ignored when the register-protect pair is 01 (byte 2 bit 0 = 0, byte 1 bit 7 = 1) and wp_n is low, unless the quad-enable bit (byte 2 bit 1) is set.
- R12: Status byte 1 is {reg-protect-0, fine, direction, level[2:0], latch, busy} from bit 7 down to bit 0. Status byte 2 has complement at bit 6, quad-enable at bit 1, reg-protect-1 at bit 0, and zeros elsewhere. A status write takes byte 1 from cmd_wdat[7:0] and byte 2 from cmd_wdat[15:8], and ignores the read-only positions.
- R13: Each cmd_end yields exactly one of rsp_ok or rsp_rej in the next cycle, and neither pulses otherwise. Unknown opcodes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_end | input | 1 | One-cycle strobe: chip select rose with a decoded command |
| cmd_op | input | 8 | Opcode |
| cmd_sect | input | 9 | Target address bits 20..12 (4 KB sector index) |
| cmd_nbits | input | 5 | Data bits clocked in after the opcode (status write) |
| cmd_wdat | input | 16 | Status write data: [7:0] byte 1, [15:8] byte 2 |
| wp_n | input | 1 | Write-protect pin level, active low |
| rsp_ok | output | 1 | Command accepted (one-cycle pulse) |
| rsp_rej | output | 1 | Command ignored (one-cycle pulse) |
| busy | output | 1 | Program, erase or status write in progress |
| wel | output | 1 | Write-enable latch |
| sr1 | output | 8 | Status byte 1 |
| sr2 | output | 8 | Status byte 2 |
| op_done | output | 1 | One-cycle pulse when busy ends |

## Verification
A wrong protect count or a mis-selected end of the array shows as a flipped accept or ignore pulse on the first erase or program aimed at a sector on the span's edge. The bench therefore places targets on both sides of every boundary it configures. A stuck or early latch or busy state shows within one cycle on wel, busy or the reply of the next command. A status write that is applied too early or lost shows on sr1 and sr2 once busy falls, and the configuration checks that follow would then disagree with the scoreboard.

// File: rtl/wrprot_pkg.sv
package wrprot_pkg;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_RDSR1  = 8'h05;
    localparam logic [7:0] OP_RDSR2  = 8'h35;
    localparam logic [7:0] OP_WRSR   = 8'h01;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_ER4K   = 8'h20;
    localparam logic [7:0] OP_ER32K  = 8'h52;
    localparam logic [7:0] OP_ER64K  = 8'hD8;
    localparam logic [7:0] OP_ERALLA = 8'hC7;
    localparam logic [7:0] OP_ERALLB = 8'h60;

    typedef enum logic [2:0] {
        CLS_NONE, CLS_WREN, CLS_WRDI, CLS_RDSR, CLS_PROG, CLS_ERASE, CLS_WRSR
    } cmd_cls_e;

    // writable part of status byte 1, bit 7 down to bit 2
    typedef struct packed {
        logic       srp0;
        logic       fine;
        logic       dir;
        logic [2:0] lvl;
    } prot_lo_t;

    // writable part of status byte 2
    typedef struct packed {
        logic cmp;
        logic qe;
        logic srp1;
    } prot_hi_t;

    function automatic logic is_modify(cmd_cls_e c);
        return (c == CLS_PROG) || (c == CLS_ERASE) || (c == CLS_WRSR);
    endfunction

    function automatic logic is_modify_op(logic [7:0] op);
        return (op == OP_PROG) || (op == OP_ER4K) || (op == OP_ER32K) ||
               (op == OP_ER64K) || (op == OP_ERALLA) || (op == OP_ERALLB) ||
               (op == OP_WRSR);
    endfunction

    function automatic logic [7:0] pack_sr1(prot_lo_t lo, logic latch, logic bsy);
        return {lo, latch, bsy};
    endfunction

    function automatic logic [7:0] pack_sr2(prot_hi_t hi);
        return {1'b0, hi.cmp, 4'b0000, hi.qe, hi.srp1};
    endfunction

    function automatic prot_hi_t unpack_sr2(logic [7:0] b);
        prot_hi_t h;
        h.cmp  = b[6];
        h.qe   = b[1];
        h.srp1 = b[0];
        return h;
    endfunction

endpackage

// File: rtl/wrprot_decode.sv
module wrprot_decode
    import wrprot_pkg::*;
#(
    parameter int SI_W       = 9,
    parameter int BLK_SECT_W = 4
) (
    input  logic [7:0]      op,
    input  logic [SI_W-1:0] sect,
    output cmd_cls_e        cls,
    output logic [SI_W-1:0] lo,
    output logic [SI_W-1:0] hi
);
    localparam logic [SI_W-1:0] HALF_MASK = SI_W'((1 << (BLK_SECT_W - 1)) - 1);
    localparam logic [SI_W-1:0] BLK_MASK  = SI_W'((1 << BLK_SECT_W) - 1);
    localparam logic [SI_W-1:0] ALL_MASK  = '1;

    logic [SI_W-1:0] mask;

    always_comb begin
        mask = '0;
        cls  = CLS_NONE;
        case (op)
            OP_WREN:               cls = CLS_WREN;
            OP_WRDI:               cls = CLS_WRDI;
            OP_RDSR1, OP_RDSR2:    cls = CLS_RDSR;
            OP_WRSR:               cls = CLS_WRSR;
            OP_PROG:               cls = CLS_PROG;
            OP_ER4K:               cls = CLS_ERASE;
            OP_ER32K: begin        cls = CLS_ERASE; mask = HALF_MASK; end
            OP_ER64K: begin        cls = CLS_ERASE; mask = BLK_MASK;  end
            OP_ERALLA, OP_ERALLB: begin cls = CLS_ERASE; mask = ALL_MASK; end
            default:               cls = CLS_NONE;
        endcase
        lo = sect & ~mask;
        hi = sect | mask;
    end
endmodule

// File: rtl/wrprot_range.sv
module wrprot_range
    import wrprot_pkg::*;
#(
    parameter int SI_W       = 9,
    parameter int BLK_SECT_W = 4
) (
    input  prot_lo_t        cfg,
    input  logic            cmp,
    input  logic [SI_W-1:0] lo,
    input  logic [SI_W-1:0] hi,
    output logic            hit
);
    localparam int               CNT_W = SI_W + 1;
    localparam logic [CNT_W-1:0] ALL   = CNT_W'(1) << SI_W;

    logic [CNT_W-1:0] span;
    logic [CNT_W-1:0] rest;
    logic [CNT_W-1:0] lo_x;
    logic [CNT_W-1:0] hi_x;

    // protected span, counted in sectors
    always_comb begin
        if (cfg.lvl == 3'd0)
            span = '0;
        else if (cfg.lvl >= 3'd6)
            span = ALL;
        else if (!cfg.fine)
            span = CNT_W'(1) << (BLK_SECT_W + int'(cfg.lvl) - 1);
        else if (cfg.lvl >= 3'd4)
            span = CNT_W'(1) << (BLK_SECT_W - 1);
        else
            span = CNT_W'(1) << (int'(cfg.lvl) - 1);
    end

    assign rest = ALL - span;
    assign lo_x = {1'b0, lo};
    assign hi_x = {1'b0, hi};

    always_comb begin
        case ({cmp, cfg.dir})
            2'b00:   hit = (hi_x >= rest);  // top span protected
            2'b01:   hit = (lo_x <  span);  // bottom span protected
            2'b10:   hit = (lo_x <  rest);  // all but top span
            default: hit = (hi_x >= span);  // all but bottom span
        endcase
    end
endmodule

// File: rtl/wrprot_timer.sv
module wrprot_timer
    import wrprot_pkg::*;
#(
    parameter int PROG_CYC  = 6,
    parameter int ERASE_CYC = 12,
    parameter int SRW_CYC   = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  cmd_cls_e cls,
    output logic     busy,
    output logic     last,
    output logic     done
);
    localparam int MAX_A = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int MAXC  = (MAX_A > SRW_CYC) ? MAX_A : SRW_CYC;
    localparam int CW    = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] load;

    always_comb begin
        case (cls)
            CLS_PROG:  load = CW'(PROG_CYC - 1);
            CLS_ERASE: load = CW'(ERASE_CYC - 1);
            default:   load = CW'(SRW_CYC - 1);
        endcase
    end

    assign last = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                cnt  <= load;
            end else if (last) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else if (busy) begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/wrprot_gate.sv
module wrprot_gate
    import wrprot_pkg::*;
#(
    parameter int ADDR_W      = 21,
    parameter int SECT_SHIFT  = 12,
    parameter int BLOCK_SHIFT = 16,
    parameter int PROG_CYC    = 6,
    parameter int ERASE_CYC   = 12,
    parameter int SRW_CYC     = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cmd_end,
    input  logic [7:0]                   cmd_op,
    input  logic [ADDR_W-SECT_SHIFT-1:0] cmd_sect,
    input  logic [4:0]                   cmd_nbits,
    input  logic [15:0]                  cmd_wdat,
    input  logic                         wp_n,
    output logic                         rsp_ok,
    output logic                         rsp_rej,
    output logic                         busy,
    output logic                         wel,
    output logic [7:0]                   sr1,
    output logic [7:0]                   sr2,
    output logic                         op_done
);
    localparam int SI_W       = ADDR_W - SECT_SHIFT;
    localparam int BLK_SECT_W = BLOCK_SHIFT - SECT_SHIFT;

    cmd_cls_e        cls;
    logic [SI_W-1:0] reg_lo, reg_hi;
    logic            hit, accept, start, last, srp_lock, nbits_ok;
    prot_lo_t        lo_q, lo_pend;
    prot_hi_t        hi_q, hi_pend;
    logic            pend_q, wel_q;

    wrprot_decode #(.SI_W(SI_W), .BLK_SECT_W(BLK_SECT_W)) u_dec (
        .op(cmd_op), .sect(cmd_sect), .cls(cls), .lo(reg_lo), .hi(reg_hi)
    );

    wrprot_range #(.SI_W(SI_W), .BLK_SECT_W(BLK_SECT_W)) u_rng (
        .cfg(lo_q), .cmp(hi_q.cmp), .lo(reg_lo), .hi(reg_hi), .hit(hit)
    );

    wrprot_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .SRW_CYC(SRW_CYC)) u_tmr (
        .clk(clk), .rst(rst), .start(start), .cls(cls),
        .busy(busy), .last(last), .done(op_done)
    );

    assign srp_lock = !hi_q.srp1 && lo_q.srp0 && !wp_n && !hi_q.qe;
    assign nbits_ok = (cmd_nbits == 5'd8) || (cmd_nbits == 5'd16);

    always_comb begin
        accept = 1'b0;
        if (busy) begin
            accept = (cls == CLS_RDSR);
        end else begin
            case (cls)
                CLS_WREN, CLS_WRDI, CLS_RDSR: accept = 1'b1;
                CLS_PROG, CLS_ERASE:          accept = wel_q && !hit;
                CLS_WRSR:                     accept = wel_q && nbits_ok && !srp_lock;
                default:                      accept = 1'b0;
            endcase
        end
    end

    assign start = cmd_end && accept && is_modify(cls);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_ok  <= 1'b0;
            rsp_rej <= 1'b0;
            wel_q   <= 1'b0;
            lo_q    <= '0;
            hi_q    <= '0;
            lo_pend <= '0;
            hi_pend <= '0;
            pend_q  <= 1'b0;
        end else begin
            rsp_ok  <= cmd_end && accept;
            rsp_rej <= cmd_end && !accept;
            if (cmd_end && !busy) begin
                case (cls)
                    CLS_WREN: wel_q <= 1'b1;
                    CLS_WRDI: wel_q <= 1'b0;
                    CLS_PROG, CLS_ERASE, CLS_WRSR: if (!accept) wel_q <= 1'b0;
                    default: ;
                endcase
            end
            if (start && cls == CLS_WRSR) begin
                lo_pend <= prot_lo_t'(cmd_wdat[7:2]);
                hi_pend <= (cmd_nbits == 5'd16) ? unpack_sr2(cmd_wdat[15:8]) : hi_q;
                pend_q  <= 1'b1;
            end
            if (last) begin
                wel_q <= 1'b0;
                if (pend_q) begin
                    lo_q   <= lo_pend;
                    hi_q   <= hi_pend;
                    pend_q <= 1'b0;
                end
            end
        end
    end

    assign wel = wel_q;
    assign sr1 = pack_sr1(lo_q, wel_q, busy);
    assign sr2 = pack_sr2(hi_q);
endmodule

// File: rtl/wrprot_gate_chk.sv
module wrprot_gate_chk
    import wrprot_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cmd_end,
    input logic [7:0] cmd_op,
    input logic [4:0] cmd_nbits,
    input logic       wp_n,
    input logic       rsp_ok,
    input logic       rsp_rej,
    input logic       busy,
    input logic       wel,
    input logic [7:0] sr1,
    input logic [7:0] sr2,
    input logic       op_done
);
    // R13: one reply per command
    a_r13_one_reply: assert property (@(posedge clk) disable iff (rst)
        cmd_end |=> (rsp_ok != rsp_rej));

    // R13: no reply without a command
    a_r13_quiet: assert property (@(posedge clk) disable iff (rst)
        !cmd_end |=> !(rsp_ok || rsp_rej));

    // R7: lockout while busy
    a_r7_lockout: assert property (@(posedge clk) disable iff (rst)
        (cmd_end && busy && cmd_op != OP_RDSR1 && cmd_op != OP_RDSR2) |=> rsp_rej);

    // R7: configuration frozen while busy
    a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(sr2) && $stable(sr1[7:2])));

    // R2: modifying command needs the latch
    a_r2_needs_latch: assert property (@(posedge clk) disable iff (rst)
        (cmd_end && !wel && is_modify_op(cmd_op)) |=> rsp_rej);

    // R8: latch clear and completion pulse when busy ends
    a_r8_latch_drop: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (!wel && op_done));

    // R10: bad status-write length
    a_r10_width: assert property (@(posedge clk) disable iff (rst)
        (cmd_end && cmd_op == OP_WRSR && cmd_nbits != 5'd8 && cmd_nbits != 5'd16) |=> rsp_rej);

    // R11: register-protect lock with pin low
    a_r11_lock: assert property (@(posedge clk) disable iff (rst)
        (cmd_end && cmd_op == OP_WRSR && sr1[7] && !sr2[0] && !sr2[1] && !wp_n) |=> rsp_rej);
endmodule

bind wrprot_gate wrprot_gate_chk u_chk (
    .clk(clk), .rst(rst), .cmd_end(cmd_end), .cmd_op(cmd_op), .cmd_nbits(cmd_nbits),
    .wp_n(wp_n), .rsp_ok(rsp_ok), .rsp_rej(rsp_rej), .busy(busy), .wel(wel),
    .sr1(sr1), .sr2(sr2), .op_done(op_done)
);

// File: tb/sim_wrprot_gate.sv
module sim_wrprot_gate;
    localparam int PROG_CYC  = 6;
    localparam int ERASE_CYC = 12;
    localparam int SRW_CYC   = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_end = 1'b0;
    logic [7:0] cmd_op = 8'h00;
    logic [8:0] cmd_sect = '0;
    logic [4:0] cmd_nbits = '0;
    logic [15:0] cmd_wdat = '0;
    logic       wp_n = 1'b1;
    logic       rsp_ok, rsp_rej, busy, wel, op_done;
    logic [7:0] sr1, sr2;

    int n_checks = 0;
    int n_errors = 0;
    bit   exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    wrprot_gate #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .SRW_CYC(SRW_CYC)) u0 (
        .clk(clk), .rst(rst), .cmd_end(cmd_end), .cmd_op(cmd_op), .cmd_sect(cmd_sect),
        .cmd_nbits(cmd_nbits), .cmd_wdat(cmd_wdat), .wp_n(wp_n),
        .rsp_ok(rsp_ok), .rsp_rej(rsp_rej), .busy(busy), .wel(wel),
        .sr1(sr1), .sr2(sr2), .op_done(op_done)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a reply appears
    always @(negedge clk) begin
        if (!rst && (rsp_ok || rsp_rej)) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_errors++;
                $display("FAIL R13 unexpected reply: actual ok=%0b expected none", rsp_ok);
            end else begin
                automatic bit    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(int'(rsp_ok && !rsp_rej), int'(e), t);
            end
        end
    end

    // driver: address given in bytes, converted to a sector index
    task automatic send(input logic [7:0] op, input logic [20:0] addr, input logic [4:0] nb,
                        input logic [15:0] wd, input bit exp_ok, input string tag);
        @(negedge clk);
        exp_q.push_back(exp_ok);
        tag_q.push_back(tag);
        cmd_op = op; cmd_sect = addr[20:12]; cmd_nbits = nb; cmd_wdat = wd;
        cmd_end = 1'b1;
        @(negedge clk);
        cmd_end = 1'b0;
        #1;
        if (exp_q.size() != 0) begin
            void'(exp_q.pop_front()); void'(tag_q.pop_front());
            n_checks++; n_errors++;
            $display("FAIL R13 %s: actual no reply expected one", tag);
        end
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk); #1;
        end
    endtask

    task automatic wrsr(input logic [4:0] nb, input logic [15:0] wd, input bit exp_ok, input string tag);
        int n;
        send(8'h06, 0, 0, 0, 1, "R2 set latch");
        send(8'h01, 0, nb, wd, exp_ok, tag);
        wait_idle(n);
    endtask

    task automatic mod_op(input logic [7:0] op, input logic [20:0] addr, input bit exp_ok, input string tag);
        int n;
        send(8'h06, 0, 0, 0, 1, "R2 set latch");
        send(op, addr, 0, 0, exp_ok, tag);
        wait_idle(n);
        chk(int'(wel), 0, {tag, " latch after"});
    endtask

    initial begin
        #(8 * 200000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(sr1, 8'h00, "R1 sr1 reset");
        chk(sr2, 8'h00, "R1 sr2 reset");
        chk(int'(busy), 0, "R1 busy reset");

        send(8'h02, 21'h000000, 0, 0, 0, "R2 program without latch");
        chk(int'(busy), 0, "R2 no busy");
        send(8'h06, 0, 0, 0, 1, "R2 wren");
        chk(sr1, 8'h02, "R12 latch bit");
        send(8'h04, 0, 0, 0, 1, "R2 wrdi");
        chk(int'(wel), 0, "R2 latch cleared");

        // busy lockout
        send(8'h06, 0, 0, 0, 1, "R2 wren");
        send(8'h20, 21'h000000, 0, 0, 1, "R6 sector erase open");
        chk(sr1, 8'h03, "R12 busy and latch bits");
        send(8'h05, 0, 0, 0, 1, "R7 status read while busy");
        send(8'h04, 0, 0, 0, 0, "R7 wrdi while busy");
        chk(int'(wel), 1, "R7 latch untouched");
        send(8'hC7, 0, 0, 0, 0, "R7 erase while busy");
        wait_idle(n);
        chk(int'(wel), 0, "R8 latch clear at end");

        // busy durations
        send(8'h06, 0, 0, 0, 1, "R2 wren");
        send(8'h02, 21'h000100, 0, 0, 1, "R8 program");
        wait_idle(n);
        chk(n, PROG_CYC, "R8 program busy length");
        send(8'h06, 0, 0, 0, 1, "R2 wren");
        send(8'h01, 0, 8, 16'h0004, 1, "R10 status write 8 bits");
        chk(sr1[4:2], 0, "R8 status not yet applied");
        wait_idle(n);
        chk(n, SRW_CYC, "R8 status write busy length");
        chk(sr1, 8'h04, "R12 level in byte 1");

        // top block protection, level 1
        send(8'h06, 0, 0, 0, 1, "R2 wren");
        send(8'h20, 21'h1F0000, 0, 0, 0, "R3 top block refused");
        chk(int'(wel), 0, "R9 latch cleared on refusal");
        send(8'h06, 0, 0, 0, 1, "R2 wren");
        send(8'h20, 21'h1EF000, 0, 0, 1, "R3 below top block");
        wait_idle(n);
        chk(n, ERASE_CYC, "R8 erase busy length");
        mod_op(8'hD8, 21'h1E0000, 1, "R6 64K erase block 30");
        mod_op(8'hC7, 21'h000000, 0, "R6 chip erase with protection");

        // bottom, level 1; top, level 2
        wrsr(8, 16'h0024, 1, "R10 dir bottom");
        chk(sr1, 8'h24, "R12 dir bit");
        mod_op(8'h20, 21'h00F000, 0, "R3 bottom block refused");
        mod_op(8'h20, 21'h010000, 1, "R3 above bottom block");
        wrsr(8, 16'h0008, 1, "R10 level 2");
        mod_op(8'h20, 21'h1E0000, 0, "R3 two top blocks refused");
        mod_op(8'h20, 21'h1DF000, 1, "R3 below two blocks");
        wrsr(8, 16'h0018, 1, "R10 level 6");
        mod_op(8'h02, 21'h000000, 0, "R3 level 6 whole array");

        // fine granularity
        wrsr(8, 16'h0044, 1, "R10 fine level 1");
        mod_op(8'h20, 21'h1FF000, 0, "R4 top sector refused");
        mod_op(8'h20, 21'h1FE000, 1, "R4 next sector open");
        mod_op(8'h52, 21'h1F8000, 0, "R6 32K containing top sector");
        mod_op(8'h52, 21'h1F0000, 1, "R6 32K below");
        wrsr(8, 16'h0050, 1, "R10 fine level 4");
        mod_op(8'h02, 21'h1F8000, 0, "R4 level 4 eight sectors");
        mod_op(8'h02, 21'h1F7000, 1, "R4 level 4 ninth sector open");

        // complement
        wrsr(16, 16'h4044, 1, "R10 status write 16 bits");
        chk(sr2, 8'h40, "R12 complement bit");
        mod_op(8'h20, 21'h1FF000, 1, "R5 top sector writable");
        mod_op(8'h20, 21'h000000, 0, "R5 rest read-only");
        wrsr(8, 16'h0000, 1, "R10 8 bits keep byte 2");
        chk(sr2, 8'h40, "R10 byte 2 unchanged");
        mod_op(8'h02, 21'h100000, 0, "R5 level 0 complemented");
        send(8'h06, 0, 0, 0, 1, "R2 wren");
        send(8'h01, 0, 12, 16'h0000, 0, "R10 bad bit count");
        chk(sr2, 8'h40, "R10 byte 2 after bad count");

        // register protect with pin
        wrsr(16, 16'h0080, 1, "R11 set reg-protect-0");
        chk(sr1, 8'h80, "R12 reg-protect bit");
        wp_n = 1'b0;
        wrsr(16, 16'h0000, 0, "R11 locked by pin");
        chk(sr1, 8'h80, "R11 byte 1 kept");
        wp_n = 1'b1;
        wrsr(16, 16'h0280, 1, "R11 pin high allows");
        chk(sr2, 8'h02, "R12 quad bit");
        wp_n = 1'b0;
        wrsr(16, 16'h0000, 1, "R11 quad overrides pin");
        chk(sr1, 8'h00, "R11 byte 1 cleared");
        wp_n = 1'b1;

        mod_op(8'hC7, 21'h000000, 1, "R6 chip erase unprotected");
        mod_op(8'h60, 21'h000000, 1, "R6 chip erase alt opcode");
        send(8'hAB, 0, 0, 0, 0, "R13 unknown opcode");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule